// File: doc/BRIEF.md
# Bit-Sliced Arithmetic and Logic Unit

This block joins two words in one combinational pass. The first word is the contents of the Q register, called the Q operand. The second word is the value on the bus. The block can apply any of the sixteen two-input Boolean functions, a binary addition with carry in and carry out, or a one-bit shift of the Q operand in either direction. In a shift, the carry line fills the vacated bit and takes the bit that drops off.

The datapath is a row of identical one-bit cells, grouped four to a nibble. The word width can be any multiple of four, so a wider word only adds nibbles to the row. The control decode does not change.

A result register R copies the combinational result on each clock edge where the load strobe is high. Otherwise R keeps its value.

Top module: `slice_alu`

## Requirements
- R1: While `rst_n` is low, R reads zero at `r_out`, whatever the load strobe does.
- R2: With `op_mode` = 2'b00 (logic), each result bit i is `func_code[2*q_in[i] + bus_in[i]]`. Index 0 is selected by q=0,b=0 and index 3 by q=1,b=1, so all sixteen codes 0..15 are usable.
- R3: With `op_mode` = 2'b01 (add), `{carry_out, alu_out}` equals `q_in + bus_in + carry_in`, taken as unsigned numbers.
- R4: With `op_mode` = 2'b00, `carry_out` is 0.
- R5: With `op_mode` = 2'b10 (shift toward the MSB), `alu_out` is `q_in` moved up one place, with `carry_in` entering bit 0. The old bit WIDTH-1 leaves on `carry_out`.
- R6: With `op_mode` = 2'b11 (shift toward the LSB), `alu_out` is `q_in` moved down one place, with `carry_in` entering bit WIDTH-1. The old bit 0 leaves on `carry_out`.
- R7: On a rising edge with `load_r` high, R takes the `alu_out` value present just before that edge.
- R8: On a rising edge with `load_r` low, R keeps its value.
- R9: A WIDTH = 4 instance meets R3 and R5 on its own narrower word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register R |
| rst_n | input | 1 | Active-low reset of R |
| q_in | input | WIDTH | Q register operand |
| bus_in | input | WIDTH | Bus operand |
| carry_in | input | 1 | Carry in for add, fill bit for shifts |
| op_mode | input | 2 | 00 logic, 01 add, 10 shift toward MSB, 11 shift toward LSB |
| func_code | input | 4 | Truth table used in logic mode |
| load_r | input | 1 | Capture strobe for R |
| alu_out | output | WIDTH | Combinational result |
| carry_out | output | 1 | Carry out, or the bit shifted out |
| r_out | output | WIDTH | Contents of register R |

## Verification
Loading R and computing a new result can happen in the same cycle. The bench provokes this by raising the load strobe on consecutive cycles while the operands, the mode and the carry change on every cycle. R must then always hold the result from the cycle before the edge, never the result the new operands produce after it. The carry line also plays two roles: it is an adder input, and it is the fill bit in a shift. The bench steps through the modes with the same `carry_in` value and checks that each mode uses it only in its own role.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_ADD   = 2'b01,
        MODE_SHL   = 2'b10,
        MODE_SHR   = 2'b11
    } alu_mode_e;

    localparam int NIBBLE_BITS = 4;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import slice_alu_pkg::*;
(
    input  alu_mode_e  mode,
    input  logic [3:0] func,
    input  logic       q_bit,
    input  logic       b_bit,
    input  logic       cy_in,
    input  logic       below_bit,
    input  logic       above_bit,
    output logic       res_bit,
    output logic       cy_out
);
    logic half_sum;

    always_comb begin
        half_sum = q_bit ^ b_bit;
        cy_out   = (q_bit & b_bit) | (cy_in & half_sum);
        unique case (mode)
            MODE_LOGIC: res_bit = func[{q_bit, b_bit}];
            MODE_ADD:   res_bit = half_sum ^ cy_in;
            MODE_SHL:   res_bit = below_bit;
            MODE_SHR:   res_bit = above_bit;
            default:    res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_nibble.sv
module alu_nibble
    import slice_alu_pkg::*;
#(
    parameter int SLICES = NIBBLE_BITS
) (
    input  alu_mode_e         mode,
    input  logic [3:0]        func,
    input  logic [SLICES-1:0] q_nib,
    input  logic [SLICES-1:0] b_nib,
    input  logic              cy_in,
    input  logic              below_in,
    input  logic              above_in,
    output logic [SLICES-1:0] res_nib,
    output logic              cy_out
);
    logic [SLICES:0] chain;
    assign chain[0] = cy_in;
    assign cy_out   = chain[SLICES];

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        logic below_w, above_w;
        if (i == 0) begin : g_lo
            assign below_w = below_in;
        end else begin : g_lo_mid
            assign below_w = q_nib[i-1];
        end
        if (i == SLICES - 1) begin : g_hi
            assign above_w = above_in;
        end else begin : g_hi_mid
            assign above_w = q_nib[i+1];
        end

        alu_bit_slice u_slice (
            .mode      (mode),
            .func      (func),
            .q_bit     (q_nib[i]),
            .b_bit     (b_nib[i]),
            .cy_in     (chain[i]),
            .below_bit (below_w),
            .above_bit (above_w),
            .res_bit   (res_nib[i]),
            .cy_out    (chain[i+1])
        );
    end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] q_in,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             carry_in,
    input  logic [1:0]       op_mode,
    input  logic [3:0]       func_code,
    input  logic             load_r,
    output logic [WIDTH-1:0] alu_out,
    output logic             carry_out,
    output logic [WIDTH-1:0] r_out
);
    localparam int NIBBLES = WIDTH / NIBBLE_BITS;

    if ((WIDTH % NIBBLE_BITS) != 0 || WIDTH < NIBBLE_BITS) begin : g_bad_width
        $error("slice_alu: WIDTH must be a positive multiple of 4");
    end

    typedef struct packed {
        logic [WIDTH-1:0] r;
    } state_t;

    alu_mode_e        mode_e;
    logic [NIBBLES:0] nib_cy;
    state_t           st_d, st_q;

    assign mode_e    = alu_mode_e'(op_mode);
    assign nib_cy[0] = carry_in;

    for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
        localparam int LO = k * NIBBLE_BITS;
        localparam int HI = LO + NIBBLE_BITS - 1;
        logic below_w, above_w;
        if (k == 0) begin : g_first
            assign below_w = carry_in;
        end else begin : g_first_mid
            assign below_w = q_in[LO-1];
        end
        if (k == NIBBLES - 1) begin : g_last
            assign above_w = carry_in;
        end else begin : g_last_mid
            assign above_w = q_in[HI+1];
        end

        alu_nibble #(.SLICES(NIBBLE_BITS)) u_nibble (
            .mode     (mode_e),
            .func     (func_code),
            .q_nib    (q_in[HI:LO]),
            .b_nib    (bus_in[HI:LO]),
            .cy_in    (nib_cy[k]),
            .below_in (below_w),
            .above_in (above_w),
            .res_nib  (alu_out[HI:LO]),
            .cy_out   (nib_cy[k+1])
        );
    end

    always_comb begin
        unique case (mode_e)
            MODE_ADD: carry_out = nib_cy[NIBBLES];
            MODE_SHL: carry_out = q_in[WIDTH-1];
            MODE_SHR: carry_out = q_in[0];
            default:  carry_out = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (load_r) begin
            st_d.r = alu_out;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign r_out = st_q.r;
endmodule

// File: rtl/slice_alu_checker.sv
module slice_alu_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] q_in,
    input logic [WIDTH-1:0] bus_in,
    input logic             carry_in,
    input logic [1:0]       op_mode,
    input logic [3:0]       func_code,
    input logic             load_r,
    input logic [WIDTH-1:0] alu_out,
    input logic             carry_out,
    input logic [WIDTH-1:0] r_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assert_logic_truth_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (op_mode == 2'b00) |-> (alu_out[i] == func_code[{q_in[i], bus_in[i]}]));
    end

    assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b01) |->
        ({carry_out, alu_out} == ({1'b0, q_in} + {1'b0, bus_in} + {{WIDTH{1'b0}}, carry_in})));

    assert_logic_no_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b00) |-> !carry_out);

    assert_shift_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b10) |->
        (carry_out == q_in[WIDTH-1] && alu_out[0] == carry_in &&
         alu_out[WIDTH-1:1] == q_in[WIDTH-2:0]));

    assert_shift_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b11) |->
        (carry_out == q_in[0] && alu_out[WIDTH-1] == carry_in &&
         alu_out[WIDTH-2:0] == q_in[WIDTH-1:1]));

    assert_load_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_r |=> (r_out == $past(alu_out)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_r |=> $stable(r_out));
endmodule

bind slice_alu slice_alu_checker #(.WIDTH(WIDTH)) u_slice_alu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_in      (q_in),
    .bus_in    (bus_in),
    .carry_in  (carry_in),
    .op_mode   (op_mode),
    .func_code (func_code),
    .load_r    (load_r),
    .alu_out   (alu_out),
    .carry_out (carry_out),
    .r_out     (r_out)
);

// File: tb/slice_alu_bench.sv
`timescale 1ns/1ps
module slice_alu_bench;
    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n;
    logic [W-1:0] q, b;
    logic         cin, ld;
    logic [1:0]   mode;
    logic [3:0]   code;
    logic [W-1:0] alu_out, r_out;
    logic         cout;

    logic [3:0] nq, nb, nres, nr;
    logic       ncin, ncout;
    logic [1:0] nmode;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_r;
    string        r_tag;

    slice_alu #(.WIDTH(W)) u_slice_alu (
        .clk(clk), .rst_n(rst_n), .q_in(q), .bus_in(b), .carry_in(cin),
        .op_mode(mode), .func_code(code), .load_r(ld),
        .alu_out(alu_out), .carry_out(cout), .r_out(r_out)
    );

    slice_alu #(.WIDTH(4)) u_narrow (
        .clk(clk), .rst_n(rst_n), .q_in(nq), .bus_in(nb), .carry_in(ncin),
        .op_mode(nmode), .func_code(4'h0), .load_r(1'b0),
        .alu_out(nres), .carry_out(ncout), .r_out(nr)
    );

    // Behavioural reference for a word of w bits (w <= W).
    function automatic void ref_alu(input logic [1:0] m, input logic [3:0] c,
                                    input logic [W-1:0] a, input logic [W-1:0] d,
                                    input logic ci, input int w,
                                    output logic [W-1:0] res, output logic co);
        logic [W-1:0] mask;
        int sum;
        mask = (W'(1) << w) - W'(1);
        res = '0;
        co  = 1'b0;
        case (m)
            2'd0: for (int i = 0; i < w; i++) res[i] = c[2 * int'(a[i]) + int'(d[i])];
            2'd1: begin
                sum = int'(a & mask) + int'(d & mask) + int'(ci);
                res = W'(sum) & mask;
                co  = ((sum >> w) & 1) == 1;
            end
            2'd2: begin
                res = ((a << 1) | W'(ci)) & mask;
                co  = a[w-1];
            end
            default: begin
                res = ((a & mask) >> 1) | (W'(ci) << (w - 1));
                co  = a[0];
            end
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic [3:0] c, input logic [W-1:0] a,
                        input logic [W-1:0] d, input logic ci, input logic ld_i);
        logic [W-1:0] er;
        logic         ec;
        string        tag;
        @(negedge clk);
        check(r_tag, "register R", {1'b0, r_out}, {1'b0, exp_r});
        mode = m; code = c; q = a; b = d; cin = ci; ld = ld_i;
        #5;
        ref_alu(m, c, a, d, ci, W, er, ec);
        tag = (m == 2'd0) ? "R2" : (m == 2'd1) ? "R3" : (m == 2'd2) ? "R5" : "R6";
        check(tag, "result", {1'b0, alu_out}, {1'b0, er});
        check((m == 2'd0) ? "R4" : tag, "carry", {{W{1'b0}}, cout}, {{W{1'b0}}, ec});
        if (ld_i) begin
            exp_r = er;
            r_tag = "R7";
        end else begin
            r_tag = "R8";
        end
    endtask

    task automatic narrow_step(input logic [1:0] m, input logic [3:0] a,
                               input logic [3:0] d, input logic ci);
        logic [W-1:0] er;
        logic         ec;
        @(negedge clk);
        nmode = m; nq = a; nb = d; ncin = ci;
        #5;
        ref_alu(m, 4'h0, W'(a), W'(d), ci, 4, er, ec);
        check("R9", "narrow result", {1'b0, W'(nres)}, {1'b0, er});
        check("R9", "narrow carry", {{W{1'b0}}, ncout}, {{W{1'b0}}, ec});
    endtask

    initial begin
        #4_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; q = 8'h5A; b = 8'h3C; cin = 1'b1; mode = 2'b01; code = 4'h6; ld = 1'b1;
        nq = 4'h0; nb = 4'h0; ncin = 1'b0; nmode = 2'b01;
        exp_r = '0; r_tag = "R1";
        repeat (3) @(negedge clk);
        check("R1", "R in reset", {1'b0, r_out}, '0);
        ld = 1'b0;
        @(negedge clk);
        check("R1", "R after reset", {1'b0, r_out}, '0);
        rst_n = 1'b1;

        // R2, R4: all sixteen truth tables over every operand pair.
        for (int c = 0; c < 16; c++) step(2'd0, 4'(c), 8'hF0, 8'hCC, c[0], c[1]);
        // R3: carry corners, including 1+1+1 on the low bit.
        step(2'd1, 4'h0, 8'h01, 8'h01, 1'b1, 1'b1);
        step(2'd1, 4'h0, 8'hFF, 8'h01, 1'b0, 1'b1);
        step(2'd1, 4'h0, 8'hFF, 8'hFF, 1'b1, 1'b0);
        step(2'd1, 4'h0, 8'h0F, 8'h00, 1'b1, 1'b1);
        step(2'd1, 4'h0, 8'h00, 8'h00, 1'b0, 1'b0);
        // R5, R6: the fill bit and the bit pushed out.
        step(2'd2, 4'h0, 8'h80, 8'h00, 1'b1, 1'b1);
        step(2'd2, 4'h0, 8'h7F, 8'hFF, 1'b0, 1'b1);
        step(2'd3, 4'h0, 8'h01, 8'h00, 1'b1, 1'b1);
        step(2'd3, 4'h0, 8'hFE, 8'hFF, 1'b0, 1'b0);
        // Same carry value under every mode, with a load on each cycle.
        for (int m = 0; m < 4; m++) step(2'(m), 4'h9, 8'hA5, 8'h5A, 1'b1, 1'b1);
        // R7, R8: load collides with changing operands.
        for (int n = 0; n < 300; n++)
            step(2'($urandom), 4'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 1'($urandom));
        step(2'd0, 4'h0, 8'h00, 8'h00, 1'b0, 1'b0);
        step(2'd0, 4'h0, 8'h00, 8'h00, 1'b0, 1'b0);

        // R9: a single-nibble instance.
        narrow_step(2'd1, 4'hF, 4'h1, 1'b0);
        narrow_step(2'd1, 4'h7, 4'h8, 1'b1);
        narrow_step(2'd2, 4'h8, 4'h0, 1'b1);
        narrow_step(2'd2, 4'h3, 4'h0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule